// File: doc/BRIEF.md
# Step Attenuator Control Register

This block is the control logic that sits in front of a 7-bit binary-weighted step attenuator. It samples a mode pin, a three-wire serial port (data, shift clock and latch enable) and a 7-bit parallel word, all against a fast system clock. It produces a registered attenuation word whose bits drive the bypass switches of the weighted stages. It also produces the same setting decoded as a count of 0.25 dB steps.

The mode pin selects the source of the word:
- **Serial mode:** bits are shifted in, then moved to the output while latch enable is high.
- **Parallel mode, latch enable held high:** the output tracks the parallel word.
- **Parallel mode, latch enable pulsed:** the parallel word is captured on the rising edge and held after the falling edge.

Latch enable does three jobs. It gates the shift clock, it opens the output latch, and at power-up (modelled by reset) a low latch enable leaves the word at full attenuation.

Top module: `step_atten_ctrl`

## Requirements
- R1: With `ser_mode_i` high the output is loaded only from the serial shift register, and the parallel word has no effect. With it low the output is loaded only from `par_word_i`, and shift clocks do not alter the shift register.
- R2: In serial mode each rising edge of `sclk_i`, while latch enable is low, shifts `sdata_i` into bit 0 and moves the older bits up. After seven edges, the first bit sent sits in bit 6 (16 dB) and the last bit sent sits in bit 0 (0.25 dB).
- R3: A rising `sclk_i` edge that is seen while latch enable is high, including one in the same synchronised cycle as the latch rising, leaves the shift register unchanged.
- R4: In serial mode, while latch enable is high, the output word equals the shift register. While latch enable is low, the output word holds its value.
- R5: In parallel mode with latch enable held high, the output word follows `par_word_i`.
- R6: In parallel mode with latch enable low, changes to `par_word_i` do not reach the output. Raising latch enable loads the present word, and lowering it holds that word.
- R7: `atten_qdb_o` is the sum of the selected stage weights in 0.25 dB units, where bit i weighs 2^i. It ranges from 0 (all bits clear) to 127 (all bits set, 31.75 dB).
- R8: After reset, with latch enable low, the output word is 7'h7F. It stays 7'h7F until latch enable is first seen high.
- R9: A serial burst of more or fewer than seven shift edges leaves the last seven bits received in the shift register.
- R10: Every pin passes through two synchroniser flops. A pin change made between clock edges reaches the output register on the third rising edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| ser_mode_i | input | 1 | 1 = serial control, 0 = parallel control |
| sclk_i | input | 1 | Serial shift clock pin |
| sdata_i | input | 1 | Serial data pin, MSB first |
| latch_en_i | input | 1 | Latch enable pin |
| par_word_i | input | 7 | Parallel attenuation word, bit 6 = 16 dB |
| atten_word_o | output | 7 | Registered stage-enable word |
| atten_qdb_o | output | 7 | Attenuation in 0.25 dB steps |

## Verification
A shift-clock rising edge and a latch-enable rising edge can land in the same synchronised cycle. In that cycle the shift must be suppressed, and the old register contents must be copied to the output. The bench provokes this by raising `sclk_i` and `latch_en_i` in the same clock phase with a data bit pending. It judges the result in two places: the output while the latch is open must show the old word and not the word shifted by one bit, and a later bare latch pulse must still show the old word.

// File: rtl/step_atten_pkg.sv
package step_atten_pkg;
  parameter int unsigned WORD_W = 7;
  parameter int unsigned SYNC_N = 2;
  typedef logic [WORD_W-1:0] att_word_t;
  typedef struct packed {
    logic      mode;
    logic      sclk;
    logic      sdata;
    logic      latch;
    att_word_t par;
  } pins_t;
  localparam int unsigned PINS_W = $bits(pins_t);
endpackage

// File: rtl/sa_pin_sync.sv
module sa_pin_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/sa_out_latch.sv
module sa_out_latch #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         sel_ser_i,
  input  logic [W-1:0] ser_word_i,
  input  logic [W-1:0] par_word_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q;

  // power-up state is full attenuation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '1;
    else if (load_i) word_q <= sel_ser_i ? ser_word_i : par_word_i;
  end

  assign word_o = word_q;
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import step_atten_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_mode_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              latch_en_i,
  input  logic [WORD_W-1:0] par_word_i,
  output logic [WORD_W-1:0] atten_word_o,
  output logic [WORD_W-1:0] atten_qdb_o
);
  pins_t     pins_raw, pins_s;
  logic      mode_s, latch_s, sdata_s, sclk_s, sclk_q, sclk_rise, shift_en;
  att_word_t par_s, shreg;

  assign pins_raw = '{mode: ser_mode_i, sclk: sclk_i, sdata: sdata_i,
                      latch: latch_en_i, par: par_word_i};

  sa_pin_sync #(.W(PINS_W), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign mode_s  = pins_s.mode;
  assign latch_s = pins_s.latch;
  assign sdata_s = pins_s.sdata;
  assign sclk_s  = pins_s.sclk;
  assign par_s   = pins_s.par;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  // shift clock is masked while the latch is open
  assign shift_en  = mode_s & sclk_rise & ~latch_s;

  sa_shift_reg #(.W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .bit_i     (sdata_s),
    .word_o    (shreg)
  );

  sa_out_latch #(.W(WORD_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (latch_s),
    .sel_ser_i (mode_s),
    .ser_word_i(shreg),
    .par_word_i(par_s),
    .word_o    (atten_word_o)
  );

  // stage i weighs 2^i quarter-dB steps
  always_comb begin
    atten_qdb_o = '0;
    for (int i = 0; i < int'(WORD_W); i++)
      if (atten_word_o[i]) atten_qdb_o = atten_qdb_o + (WORD_W'(1) << i);
  end
endmodule

// File: rtl/step_atten_chk.sv
module step_atten_chk #(
  parameter int unsigned W = 7
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mode_s,
  input logic         latch_s,
  input logic         sclk_rise,
  input logic         sdata_s,
  input logic [W-1:0] par_s,
  input logic [W-1:0] shreg,
  input logic [W-1:0] word,
  input logic [W-1:0] qdb
);
  a_r7_qdb_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qdb == word);

  a_r3_shift_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_s |=> $stable(shreg));

  a_r1_par_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_s |=> $stable(shreg));

  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s && sclk_rise && !latch_s) |=> shreg == {$past(shreg[W-2:0]), $past(sdata_s)});

  a_r4_hold_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_s |=> $stable(word));

  a_r4_serial_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s && latch_s) |=> word == $past(shreg));

  a_r5_par_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_s && latch_s) |=> word == $past(par_s));
endmodule

bind step_atten_ctrl step_atten_chk #(.W(step_atten_pkg::WORD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_s   (mode_s),
  .latch_s  (latch_s),
  .sclk_rise(sclk_rise),
  .sdata_s  (sdata_s),
  .par_s    (par_s),
  .shreg    (shreg),
  .word     (atten_word_o),
  .qdb      (atten_qdb_o)
);

// File: tb/step_atten_ctrl_bench.sv
module step_atten_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_mode, sclk, sdata, latch_en;
  logic [6:0] par_word, word, qdb;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  step_atten_ctrl u_step_atten_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ser_mode_i  (ser_mode),
    .sclk_i      (sclk),
    .sdata_i     (sdata),
    .latch_en_i  (latch_en),
    .par_word_i  (par_word),
    .atten_word_o(word),
    .atten_qdb_o (qdb)
  );

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(logic [15:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = bits[i]; wait_n(4);
      sclk  = 1'b1;    wait_n(4);
      sclk  = 1'b0;    wait_n(4);
    end
  endtask

  task automatic pulse_latch();
    latch_en = 1'b1; wait_n(4);
    latch_en = 1'b0; wait_n(4);
  endtask

  task automatic t_reset_and_serial();
    chk("R8 reset word", word, 7'h7F);
    chk("R7 reset qdb", qdb, 7'd127);
    send_bits(16'h0053, 7);
    chk("R8 held until latch", word, 7'h7F);
    pulse_latch();
    chk("R2 R4 serial load", word, 7'h53);
    chk("R7 qdb 83", qdb, 7'd83);
  endtask

  task automatic t_shift_mask();
    latch_en = 1'b1; wait_n(4);
    send_bits(16'h002C, 7);
    chk("R4 open latch shows shreg", word, 7'h53);
    latch_en = 1'b0; wait_n(4);
    pulse_latch();
    chk("R3 clocks masked while open", word, 7'h53);
  endtask

  task automatic t_collision();
    sdata = 1'b1; wait_n(4);
    sclk = 1'b1; latch_en = 1'b1; wait_n(4);
    chk("R3 same-cycle edge suppressed", word, 7'h53);
    latch_en = 1'b0; wait_n(4);
    sclk = 1'b0; wait_n(4);
    pulse_latch();
    chk("R3 shreg unchanged after collision", word, 7'h53);
  endtask

  task automatic t_odd_bursts();
    send_bits(16'h03C5, 10);
    pulse_latch();
    chk("R9 long burst keeps last 7", word, 7'h45);
    send_bits(16'h0003, 3);
    pulse_latch();
    chk("R9 short burst", word, 7'h2B);
  endtask

  task automatic t_mode_sel();
    ser_mode = 1'b1; latch_en = 1'b1; par_word = 7'h11; wait_n(4);
    chk("R1 serial ignores parallel word", word, 7'h2B);
    latch_en = 1'b0; wait_n(4);
    ser_mode = 1'b0; wait_n(4);
    send_bits(16'h007F, 7);
    ser_mode = 1'b1; wait_n(4);
    pulse_latch();
    chk("R1 parallel mode does not shift", word, 7'h2B);
  endtask

  task automatic t_direct();
    ser_mode = 1'b0; latch_en = 1'b1; par_word = 7'h12; wait_n(4);
    chk("R5 direct follow 12", word, 7'h12);
    par_word = 7'h7E; wait_n(4);
    chk("R5 direct follow 7E", word, 7'h7E);
    par_word = 7'h00; wait_n(4);
    chk("R7 qdb zero", qdb, 7'd0);
    par_word = 7'h33;
    wait_n(2);
    chk("R10 not before third edge", word, 7'h00);
    wait_n(1);
    chk("R10 at third edge", word, 7'h33);
  endtask

  task automatic t_latched();
    latch_en = 1'b0; wait_n(4);
    par_word = 7'h01; wait_n(4);
    chk("R6 closed latch ignores word", word, 7'h33);
    latch_en = 1'b1; wait_n(4);
    chk("R6 rising loads", word, 7'h01);
    latch_en = 1'b0; wait_n(4);
    par_word = 7'h55; wait_n(4);
    chk("R6 falling holds", word, 7'h01);
    chk("R7 qdb 1", qdb, 7'd1);
  endtask

  initial begin
    ser_mode = 1'b1; sclk = 1'b0; sdata = 1'b0; latch_en = 1'b0; par_word = 7'h00;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    t_reset_and_serial();
    t_shift_mask();
    t_collision();
    t_odd_bursts();
    t_mode_sel();
    t_direct();
    t_latched();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule